// File: doc/BRIEF.md
# Constant-Off-Time Current Limiter

This block regulates load current in one bridge channel. It works only on digital comparator flags. One flag reports that the current has gone over the regulation level. Two more flags report a short: one for the high-side switch and one for the low-side switch. The gate logic also tells the block whether the bridge is active, and it sends a one-cycle pulse each time the bridge outputs change state.

Each output change or activation starts a blanking window. Inside that window the over-limit flag has no effect, but a short can still be seen. Once the window closes, an over-limit flag starts a fixed off-time. During the off-time the block asks the gate logic to put the outputs in high impedance. When the off-time ends, a new blanking window begins before the block looks at the over-limit flag again.

A short in any active state is handled differently. It raises a one-cycle fault pulse and a force-off request. Both are held off only by the gate logic taking the bridge out of the active state, so the short becomes a latched fault instead of being regulated. Window lengths are given in microseconds and scaled by a cycles-per-microsecond parameter.

Top module: `cot_limiter`

## Requirements
- R1: While reset is high, and after it, until the bridge becomes active, `force_off_o` and `short_flt_o` are 0.
- R2: A blanking window of BLANK_CYC cycles follows the edge at which activation or a transition pulse is sampled. An over-limit flag sampled at any of the BLANK_CYC following edges has no effect. A flag held high takes effect at edge BLANK_CYC+1.
- R3: After blanking, an over-limit flag sampled at a clock edge sets `force_off_o` to 1 after that edge. It then stays at 1 for exactly OFF_CYC cycles.
- R4: Over-limit flags and transition pulses that arrive during an off-time change neither its length nor its end.
- R5: When an off-time ends, a new BLANK_CYC blanking window starts. Two rises of `force_off_o` caused by over-limit trips are therefore at least OFF_CYC+BLANK_CYC+1 cycles apart.
- R6: A short flag (high-side or low-side) sampled while the bridge is active, in blanking, armed or off-time, sets `short_flt_o` and `force_off_o` to 1 after that edge. No off-time is started.
- R7: `short_flt_o` is a single-cycle pulse, given at most once per active period, even when short flags stay high. After a short, `force_off_o` stays at 1 while the bridge stays active.
- R8: An inactive bridge flag sampled at an edge brings both outputs to 0 after that edge and clears both timers. While the bridge is inactive, short and over-limit flags are ignored.
- R9: A transition pulse sampled during blanking or while armed restarts the blanking window. It takes priority over an over-limit flag sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lim_trip_i | input | 1 | Over-limit comparator flag |
| short_hs_i | input | 1 | High-side short comparator flag |
| short_ls_i | input | 1 | Low-side short comparator flag |
| bridge_act_i | input | 1 | Bridge enabled and not latched off |
| out_edge_i | input | 1 | One-cycle pulse on each output transition |
| force_off_o | output | 1 | Request to put the bridge outputs in high impedance |
| short_flt_o | output | 1 | One-cycle short-fault pulse |

## Verification
The assertions assume the following about the inputs:
- The gate logic takes the bridge out of the active state after a short fault, so a force-off that comes from a short is only released by deactivation.
- Transition pulses come from the gate logic's own output edges, so none arrive inside the window the block is timing except those the requirements mention.
- All flags are already synchronous to the clock.

The stimulus follows these rules. It changes inputs only on the falling clock edge. It deactivates the bridge after every short. It uses only single-cycle transition pulses.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BLANK = 3'd1,
    ST_ARMED = 3'd2,
    ST_OFF   = 3'd3,
    ST_LATCH = 3'd4
  } cot_state_e;

  localparam int unsigned N_TIMERS = 2;
  localparam int unsigned TMR_BLANK = 0;
  localparam int unsigned TMR_OFF   = 1;
endpackage

// File: rtl/cot_timer.sv
module cot_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic start_i,
  output logic fin_o,
  output logic busy_o
);
  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fin_o  = run_q && (cnt_q == '0);
  assign busy_o = run_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD);

  // R8
  clr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !busy_o);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !clr_i) |=> busy_o);
endmodule

// File: rtl/cot_fsm.sv
module cot_fsm
  import cot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bridge_act_i,
  input  logic lim_trip_i,
  input  logic short_any_i,
  input  logic out_edge_i,
  input  logic blank_fin_i,
  input  logic off_fin_i,
  output logic blank_start_o,
  output logic off_start_o,
  output logic tmr_clr_o,
  output logic force_off_o,
  output logic short_flt_o
);
  cot_state_e st_q, st_d;

  always_comb begin
    st_d          = st_q;
    blank_start_o = 1'b0;
    off_start_o   = 1'b0;
    if (!bridge_act_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d          = ST_BLANK;
          blank_start_o = 1'b1;
        end
        ST_BLANK: begin
          if (short_any_i)      st_d = ST_LATCH;
          else if (out_edge_i)  blank_start_o = 1'b1;
          else if (blank_fin_i) st_d = ST_ARMED;
        end
        ST_ARMED: begin
          if (short_any_i) begin
            st_d = ST_LATCH;
          end else if (out_edge_i) begin
            st_d          = ST_BLANK;
            blank_start_o = 1'b1;
          end else if (lim_trip_i) begin
            st_d        = ST_OFF;
            off_start_o = 1'b1;
          end
        end
        ST_OFF: begin
          if (short_any_i) begin
            st_d = ST_LATCH;
          end else if (off_fin_i) begin
            st_d          = ST_BLANK;
            blank_start_o = 1'b1;
          end
        end
        ST_LATCH: st_d = ST_LATCH;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  assign tmr_clr_o = (st_d == ST_IDLE) || (st_d == ST_LATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      force_off_o <= 1'b0;
      short_flt_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      force_off_o <= (st_d == ST_OFF) || (st_d == ST_LATCH);
      short_flt_o <= (st_d == ST_LATCH) && (st_q != ST_LATCH);
    end
  end

  // R7
  short_single_chk: assert property (@(posedge clk) disable iff (rst)
    short_flt_o |=> !short_flt_o);

  // R8
  disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bridge_act_i |=> (!force_off_o && !short_flt_o));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (short_flt_o && bridge_act_i) |=> force_off_o);

  // R6
  short_act_chk: assert property (@(posedge clk) disable iff (rst)
    (short_any_i && bridge_act_i && (st_q != ST_IDLE)) |=> force_off_o);
endmodule

// File: rtl/cot_limiter.sv
module cot_limiter
  import cot_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned OFF_US     = 20,
  parameter int unsigned BLANK_US   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lim_trip_i,
  input  logic short_hs_i,
  input  logic short_ls_i,
  input  logic bridge_act_i,
  input  logic out_edge_i,
  output logic force_off_o,
  output logic short_flt_o
);
  localparam int unsigned OFF_CYC   = OFF_US * CYC_PER_US;
  localparam int unsigned BLANK_CYC = BLANK_US * CYC_PER_US;
  localparam int unsigned GAP_MIN   = OFF_CYC + BLANK_CYC + 1;
  localparam int unsigned GW        = $clog2(GAP_MIN + 2) + 1;

  logic [N_TIMERS-1:0] t_start, t_fin, t_busy;
  logic                tmr_clr;
  logic                short_any;

  assign short_any = short_hs_i | short_ls_i;

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    localparam int unsigned LEN = (g == TMR_BLANK) ? BLANK_CYC : OFF_CYC;
    cot_timer #(.LEN(LEN)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (tmr_clr),
      .start_i (t_start[g]),
      .fin_o   (t_fin[g]),
      .busy_o  (t_busy[g])
    );
  end

  cot_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .bridge_act_i  (bridge_act_i),
    .lim_trip_i    (lim_trip_i),
    .short_any_i   (short_any),
    .out_edge_i    (out_edge_i),
    .blank_fin_i   (t_fin[TMR_BLANK]),
    .off_fin_i     (t_fin[TMR_OFF]),
    .blank_start_o (t_start[TMR_BLANK]),
    .off_start_o   (t_start[TMR_OFF]),
    .tmr_clr_o     (tmr_clr),
    .force_off_o   (force_off_o),
    .short_flt_o   (short_flt_o)
  );

  // Checker counters: length of a force-off run and spacing between rises.
  logic          fo_prev_q, seen_q;
  logic [GW-1:0] run_q, gap_q;
  logic          rise_now;

  assign rise_now = force_off_o && !fo_prev_q;

  always_ff @(posedge clk) begin
    if (rst || !bridge_act_i) begin
      fo_prev_q <= 1'b0;
      seen_q    <= 1'b0;
      run_q     <= '0;
      gap_q     <= '0;
    end else begin
      fo_prev_q <= force_off_o;
      run_q     <= force_off_o ? ((run_q == '1) ? run_q : run_q + 1'b1) : '0;
      if (rise_now && !short_flt_o) begin
        seen_q <= 1'b1;
        gap_q  <= GW'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R3
  off_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(force_off_o) && $past(bridge_act_i)) |-> (run_q == GW'(OFF_CYC)));

  // R5
  chop_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_now && !short_flt_o && seen_q && bridge_act_i) |-> (gap_q >= GW'(GAP_MIN)));

  // R4
  timers_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(t_busy[TMR_OFF] && t_busy[TMR_BLANK] && !t_start[TMR_BLANK]));
endmodule

// File: tb/cot_limiter_bench.sv
module cot_limiter_bench;
  localparam int unsigned CPU = 2, OFF_US = 5, BLK_US = 3;
  localparam int OFF_C = CPU * OFF_US;   // 10
  localparam int BLK_C = CPU * BLK_US;   // 6

  logic clk = 1'b0, rst = 1'b1;
  logic lim = 1'b0, shs = 1'b0, sls = 1'b0, act = 1'b0, edg = 1'b0;
  logic fo, sf;
  int   n_cmp = 0, n_err = 0, cyc = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  cot_limiter #(.CYC_PER_US(CPU), .OFF_US(OFF_US), .BLANK_US(BLK_US)) u_cot_limiter (
    .clk(clk), .rst(rst), .lim_trip_i(lim), .short_hs_i(shs), .short_ls_i(sls),
    .bridge_act_i(act), .out_edge_i(edg), .force_off_o(fo), .short_flt_o(sf)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string rq, string what, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %b expected %b", rq, what, got, exp);
    end
  endtask

  task automatic go_idle();
    act = 0; lim = 0; shs = 0; sls = 0; edg = 0;
    tick(); tick();
  endtask

  task automatic activate();
    act = 1; tick();
  endtask

  task automatic test_reset();
    rst = 1; repeat (3) tick();
    chk("R1", "force_off in reset", fo, 1'b0);
    chk("R1", "short_flt in reset", sf, 1'b0);
    rst = 0; lim = 1; tick(); tick();
    chk("R1", "force_off idle", fo, 1'b0);
    lim = 0;
  endtask

  // R2 R3 R5: held trip gives blank, off, blank, off
  task automatic test_chop();
    go_idle(); lim = 1; activate();
    for (int k = 1; k <= 2*BLK_C + OFF_C + 2; k++) begin
      tick();
      if (k <= BLK_C) chk("R2", "blank", fo, 1'b0);
      else if (k <= BLK_C + OFF_C + 1) chk("R3", "off time", fo, (k <= BLK_C + OFF_C));
      else chk("R5", "reblank", fo, (k >= 2*BLK_C + OFF_C + 2));
    end
    lim = 0;
  endtask

  // R9: transition while armed restarts blanking and beats trip
  task automatic test_restart();
    go_idle(); activate();
    repeat (BLK_C + 3) tick();
    edg = 1; lim = 1; tick(); edg = 0;
    chk("R9", "edge beats trip", fo, 1'b0);
    for (int k = 1; k <= BLK_C + 1; k++) begin
      tick();
      chk("R9", "restart window", fo, (k == BLK_C + 1));
    end
    lim = 0;
  endtask

  // R4: transition and trips during off do not stretch it
  task automatic test_off_ignore();
    go_idle(); lim = 1; activate();
    repeat (BLK_C + 3) tick();
    chk("R4", "off running", fo, 1'b1);
    edg = 1; tick(); edg = 0;
    for (int k = BLK_C + 5; k <= BLK_C + OFF_C + 2; k++) begin
      lim = k[0];
      tick();
      chk("R4", "off fixed", fo, (k <= BLK_C + OFF_C));
    end
    lim = 0;
  endtask

  // R6 R7 R8: short in blanking latches, single pulse, cleared by deactivation
  task automatic test_short();
    go_idle(); activate(); tick(); tick();
    sls = 1; tick();
    chk("R6", "short_flt low-side", sf, 1'b1);
    chk("R6", "force_off on short", fo, 1'b1);
    tick();
    chk("R7", "pulse single", sf, 1'b0);
    chk("R7", "latch held", fo, 1'b1);
    sls = 0; shs = 1;
    repeat (3) begin
      tick();
      chk("R7", "no repeat hs", sf, 1'b0);
      chk("R7", "latch held hs", fo, 1'b1);
    end
    shs = 0; act = 0; tick();
    chk("R8", "latch cleared", fo, 1'b0);
    chk("R8", "no pulse", sf, 1'b0);
    shs = 1; repeat (2) tick();
    chk("R8", "short ignored off", sf, 1'b0);
    shs = 0;
    activate(); repeat (BLK_C + 2) tick();
    shs = 1; tick(); shs = 0;
    chk("R6", "short_flt high-side armed", sf, 1'b1);
  endtask

  // R8 R2: deactivation ends off-time, reactivation reblanks
  task automatic test_disable();
    go_idle(); lim = 1; activate();
    repeat (BLK_C + 2) tick();
    chk("R3", "off before disable", fo, 1'b1);
    act = 0; tick();
    chk("R8", "disable drops force", fo, 1'b0);
    act = 1; tick();
    for (int k = 1; k <= BLK_C + 1; k++) begin
      tick();
      chk("R2", "reblank after activation", fo, (k == BLK_C + 1));
    end
    lim = 0;
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_chop();
    test_restart();
    test_off_ignore();
    test_short();
    test_disable();
    summary();
  end
endmodule